// File: doc/BRIEF.md
# Accumulator Machine Hardwired Sequencer

This block is the hardwired control unit for an 8-bit accumulator processor with four instructions: LOAD, ADD, JUMP and STORE. It keeps a single fetch/execute flag and a two-bit step counter that is decoded one-hot into four step slots. From these and the two opcode bits of the instruction register it drives one-hot datapath strobes. The strobes cover the following:
- register loads for the memory address register, memory buffer, program counter, instruction register, accumulator and ALU output buffer;
- the ALU addend source;
- the ALU add and carry-in enables;
- the memory read and write strobes.

Each instruction starts with a three-step fetch. The execute phase that follows lasts one to four steps, depending on the opcode. The counter restarts at the first step as soon as a phase ends, so no step slot is wasted. The surrounding datapath and memory act on the strobes and feed the opcode field back from the instruction register.

Top module: `accu_seq_ctrl`

## Requirements
- R1: The opcode input is decoded as 2'b00 LOAD, 2'b01 ADD, 2'b10 JUMP and 2'b11 STORE.
- R2: While reset is asserted, and on the first cycle after it is released, the controller is at fetch step 1: only mar_from_pc_o is high.
- R3: At fetch step 2, exactly these strobes are high: mem_rd_o, mbr_from_mem_o, alu_sel_pc_o, alu_add_o, alu_cin_o and alu_buf_ld_o.
- R4: At fetch step 3, only pc_from_alu_o and ir_ld_o are high. Fetch strobes never depend on opcode_i, including when the previous instruction was an ADD.
- R5: A JUMP executes in one step, with only pc_from_ir_o high, and the next cycle is fetch step 1.
- R6: A STORE executes in two steps: step 1 has mar_from_ir_o and mbr_from_ac_o, and step 2 has only mem_wr_o. Fetch step 1 follows.
- R7: A LOAD executes in three steps: step 1 has mar_from_ir_o, step 2 has mem_rd_o and mbr_from_mem_o, and step 3 has only ac_from_mbr_o. Fetch step 1 follows.
- R8: An ADD executes in four steps. Steps 1 and 2 match LOAD. Step 3 has alu_sel_mbr_o, alu_add_o and alu_buf_ld_o, with no carry-in. Step 4 has only ac_from_alu_o. Fetch step 1 follows.
- R9: mem_rd_o and mem_wr_o are never high together, and at most one source strobe is high for each of the MAR, MBR, PC and AC loads.
- R10: An asynchronous reset taken in the middle of an execute phase returns the controller to fetch step 1 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| opcode_i | input | 2 | Opcode field of the instruction register |
| mar_from_pc_o | output | 1 | Load MAR from PC |
| mar_from_ir_o | output | 1 | Load MAR from the IR address field |
| mbr_from_mem_o | output | 1 | Load MBR from memory |
| mbr_from_ac_o | output | 1 | Load MBR from AC |
| pc_from_alu_o | output | 1 | Load PC from the ALU buffer |
| pc_from_ir_o | output | 1 | Load PC from the IR address field |
| ir_ld_o | output | 1 | Load IR from MBR |
| ac_from_alu_o | output | 1 | Load AC from the ALU buffer |
| ac_from_mbr_o | output | 1 | Load AC from MBR |
| alu_sel_pc_o | output | 1 | Second ALU addend is PC |
| alu_sel_mbr_o | output | 1 | Second ALU addend is MBR |
| alu_add_o | output | 1 | ALU add enable |
| alu_cin_o | output | 1 | ALU carry-in enable |
| alu_buf_ld_o | output | 1 | Capture the ALU result in its buffer |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |

## Verification
Two pairs of actions share a cycle. At fetch step 2, the memory read and the PC increment through the ALU with carry-in happen together. At STORE step 1, the MAR and MBR loads happen together. The bench compares the full strobe vector every cycle against a per-step table, so a missing partner strobe or a stray extra strobe in those cycles is caught. It also changes opcode_i at the fetch-step-3 edge, where the instruction register would load. It holds an ADD opcode into the next fetch, and it puts junk opcodes on the input during fetch, to show that step slots shared by two phases do not leak execute strobes.

// File: rtl/accu_ctrl_pkg.sv
package accu_ctrl_pkg;

  localparam int unsigned OP_W   = 2;
  localparam int unsigned NUM_OP = 1 << OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 2'b00,
    OP_ADD   = 2'b01,
    OP_JUMP  = 2'b10,
    OP_STORE = 2'b11
  } op_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mbr_from_mem;
    logic mbr_from_ac;
    logic pc_from_alu;
    logic pc_from_ir;
    logic ir_ld;
    logic ac_from_alu;
    logic ac_from_mbr;
    logic alu_sel_pc;
    logic alu_sel_mbr;
    logic alu_add;
    logic alu_cin;
    logic alu_buf_ld;
    logic mem_rd;
    logic mem_wr;
  } strobe_t;

endpackage

// File: rtl/accu_op_decode.sv
module accu_op_decode
  import accu_ctrl_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  output logic [NUM_OP-1:0] op_oh_o
);

  // one-hot index equals opcode value: 0 LOAD, 1 ADD, 2 JUMP, 3 STORE
  for (genvar i = 0; i < NUM_OP; i++) begin : g_dec
    assign op_oh_o[i] = (op_i == OP_W'(i));
  end

endmodule

// File: rtl/accu_step_timer.sv
module accu_step_timer #(
  parameter int unsigned STEP_W = 2,
  localparam int unsigned NUM_STEPS = 1 << STEP_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 restart_i,
  output logic [NUM_STEPS-1:0] step_oh_o
);

  logic [STEP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  for (genvar s = 0; s < NUM_STEPS; s++) begin : g_step
    assign step_oh_o[s] = (cnt_q == STEP_W'(s));
  end

endmodule

// File: rtl/accu_phase_flag.sv
module accu_phase_flag
  import accu_ctrl_pkg::*;
#(
  parameter int unsigned NUM_STEPS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_STEPS-1:0] step_oh_i,
  input  logic [NUM_OP-1:0]    op_oh_i,
  output logic                 fetch_o,
  output logic                 phase_end_o
);

  localparam int unsigned FETCH_LAST = 2;

  logic fetch_q;
  logic exec_end;

  // last execute step per opcode: JUMP t1, STORE t2, LOAD t3, ADD t4
  assign exec_end = (step_oh_i[0] & op_oh_i[OP_JUMP])
                  | (step_oh_i[1] & op_oh_i[OP_STORE])
                  | (step_oh_i[2] & op_oh_i[OP_LOAD])
                  | (step_oh_i[3] & op_oh_i[OP_ADD]);

  assign phase_end_o = fetch_q ? step_oh_i[FETCH_LAST] : exec_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          fetch_q <= 1'b1;
    else if (phase_end_o) fetch_q <= ~fetch_q;
  end

  assign fetch_o = fetch_q;

  AST_FETCH_LEAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_q && step_oh_i[FETCH_LAST]) |=> (!fetch_q && step_oh_i[0])) else $error("fetch did not end at t3"); // R4

  AST_EXEC_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_q && exec_end) |=> (fetch_q && step_oh_i[0])) else $error("execute did not return to fetch t1"); // R10

endmodule

// File: rtl/accu_strobe_decode.sv
module accu_strobe_decode
  import accu_ctrl_pkg::*;
#(
  parameter int unsigned NUM_STEPS = 4
) (
  input  logic                 fetch_i,
  input  logic [NUM_STEPS-1:0] step_oh_i,
  input  logic [NUM_OP-1:0]    op_oh_i,
  output strobe_t              strobe_o
);

  logic [NUM_STEPS-1:0] f_t, x_t;
  logic is_ld, is_add, is_jmp, is_st;

  // every term is qualified by phase so a held opcode cannot leak into fetch
  assign f_t = step_oh_i & {NUM_STEPS{fetch_i}};
  assign x_t = step_oh_i & {NUM_STEPS{~fetch_i}};

  assign is_ld  = op_oh_i[OP_LOAD];
  assign is_add = op_oh_i[OP_ADD];
  assign is_jmp = op_oh_i[OP_JUMP];
  assign is_st  = op_oh_i[OP_STORE];

  always_comb begin
    strobe_o = '0;
    strobe_o.mar_from_pc  = f_t[0];
    strobe_o.mar_from_ir  = x_t[0] & (is_ld | is_add | is_st);
    strobe_o.mbr_from_ac  = x_t[0] & is_st;
    strobe_o.pc_from_ir   = x_t[0] & is_jmp;
    strobe_o.mem_rd       = f_t[1] | (x_t[1] & (is_ld | is_add));
    strobe_o.mbr_from_mem = strobe_o.mem_rd;
    strobe_o.mem_wr       = x_t[1] & is_st;
    strobe_o.alu_sel_pc   = f_t[1];
    strobe_o.alu_cin      = f_t[1];
    strobe_o.alu_sel_mbr  = x_t[2] & is_add;
    strobe_o.alu_add      = f_t[1] | strobe_o.alu_sel_mbr;
    strobe_o.alu_buf_ld   = strobe_o.alu_add;
    strobe_o.pc_from_alu  = f_t[2];
    strobe_o.ir_ld        = f_t[2];
    strobe_o.ac_from_mbr  = x_t[2] & is_ld;
    strobe_o.ac_from_alu  = x_t[3] & is_add;
  end

endmodule

// File: rtl/accu_seq_ctrl.sv
module accu_seq_ctrl
  import accu_ctrl_pkg::*;
#(
  parameter int unsigned STEP_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      opcode_i,
  output logic            mar_from_pc_o,
  output logic            mar_from_ir_o,
  output logic            mbr_from_mem_o,
  output logic            mbr_from_ac_o,
  output logic            pc_from_alu_o,
  output logic            pc_from_ir_o,
  output logic            ir_ld_o,
  output logic            ac_from_alu_o,
  output logic            ac_from_mbr_o,
  output logic            alu_sel_pc_o,
  output logic            alu_sel_mbr_o,
  output logic            alu_add_o,
  output logic            alu_cin_o,
  output logic            alu_buf_ld_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o
);

  localparam int unsigned NUM_STEPS = 1 << STEP_W;

  logic [NUM_OP-1:0]    op_oh;
  logic [NUM_STEPS-1:0] step_oh;
  logic                 fetch;
  logic                 phase_end;
  strobe_t              strb;

  accu_op_decode u_op_dec (
    .op_i    (opcode_i),
    .op_oh_o (op_oh)
  );

  accu_step_timer #(.STEP_W(STEP_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (phase_end),
    .step_oh_o (step_oh)
  );

  accu_phase_flag #(.NUM_STEPS(NUM_STEPS)) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_oh_i   (step_oh),
    .op_oh_i     (op_oh),
    .fetch_o     (fetch),
    .phase_end_o (phase_end)
  );

  accu_strobe_decode #(.NUM_STEPS(NUM_STEPS)) u_strb (
    .fetch_i   (fetch),
    .step_oh_i (step_oh),
    .op_oh_i   (op_oh),
    .strobe_o  (strb)
  );

  assign mar_from_pc_o  = strb.mar_from_pc;
  assign mar_from_ir_o  = strb.mar_from_ir;
  assign mbr_from_mem_o = strb.mbr_from_mem;
  assign mbr_from_ac_o  = strb.mbr_from_ac;
  assign pc_from_alu_o  = strb.pc_from_alu;
  assign pc_from_ir_o   = strb.pc_from_ir;
  assign ir_ld_o        = strb.ir_ld;
  assign ac_from_alu_o  = strb.ac_from_alu;
  assign ac_from_mbr_o  = strb.ac_from_mbr;
  assign alu_sel_pc_o   = strb.alu_sel_pc;
  assign alu_sel_mbr_o  = strb.alu_sel_mbr;
  assign alu_add_o      = strb.alu_add;
  assign alu_cin_o      = strb.alu_cin;
  assign alu_buf_ld_o   = strb.alu_buf_ld;
  assign mem_rd_o       = strb.mem_rd;
  assign mem_wr_o       = strb.mem_wr;

  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)) else $error("read and write together"); // R9

  AST_ONE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mar_from_pc_o, mar_from_ir_o}) && $onehot0({mbr_from_mem_o, mbr_from_ac_o}) &&
    $onehot0({pc_from_alu_o, pc_from_ir_o}) && $onehot0({ac_from_alu_o, ac_from_mbr_o}))
    else $error("register with two sources"); // R9

  AST_INC_BEFORE_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_sel_pc_o && alu_cin_o) |=> (pc_from_alu_o && ir_ld_o)) else $error("PC increment not consumed"); // R3

  AST_JUMP_REFETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_from_ir_o |=> mar_from_pc_o) else $error("jump not followed by fetch"); // R5

  AST_STORE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbr_from_ac_o |=> (mem_wr_o ##1 mar_from_pc_o)) else $error("store sequence broken"); // R6

  AST_ADD_SUM_USED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_sel_mbr_o |=> (ac_from_alu_o ##1 mar_from_pc_o)) else $error("add result not loaded"); // R8

  AST_LOAD_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ac_from_mbr_o |=> mar_from_pc_o) else $error("load not followed by fetch"); // R7

endmodule

// File: tb/accu_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module accu_seq_ctrl_tb_top;

  localparam logic [1:0] C_LOAD = 2'b00, C_ADD = 2'b01, C_JUMP = 2'b10, C_STORE = 2'b11;
  localparam int B_MAR_PC = 15, B_MAR_IR = 14, B_MBR_MEM = 13, B_MBR_AC = 12,
                 B_PC_ALU = 11, B_PC_IR = 10, B_IR = 9, B_AC_ALU = 8, B_AC_MBR = 7,
                 B_SEL_PC = 6, B_SEL_MBR = 5, B_ADD = 4, B_CIN = 3, B_BUF = 2,
                 B_RD = 1, B_WR = 0;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] opcode = 2'b00;
  logic mar_pc, mar_ir, mbr_mem, mbr_ac, pc_alu, pc_ir, ir_ld, ac_alu, ac_mbr;
  logic sel_pc, sel_mbr, alu_add, alu_cin, buf_ld, mem_rd, mem_wr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  accu_seq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .opcode_i(opcode),
    .mar_from_pc_o(mar_pc), .mar_from_ir_o(mar_ir), .mbr_from_mem_o(mbr_mem),
    .mbr_from_ac_o(mbr_ac), .pc_from_alu_o(pc_alu), .pc_from_ir_o(pc_ir),
    .ir_ld_o(ir_ld), .ac_from_alu_o(ac_alu), .ac_from_mbr_o(ac_mbr),
    .alu_sel_pc_o(sel_pc), .alu_sel_mbr_o(sel_mbr), .alu_add_o(alu_add),
    .alu_cin_o(alu_cin), .alu_buf_ld_o(buf_ld), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr)
  );

  wire [15:0] act = {mar_pc, mar_ir, mbr_mem, mbr_ac, pc_alu, pc_ir, ir_ld, ac_alu,
                     ac_mbr, sel_pc, sel_mbr, alu_add, alu_cin, buf_ld, mem_rd, mem_wr};

  function automatic logic [15:0] fetch_exp(int step);
    logic [15:0] v = '0;
    case (step)
      1: v[B_MAR_PC] = 1'b1;
      2: begin v[B_RD] = 1'b1; v[B_MBR_MEM] = 1'b1; v[B_SEL_PC] = 1'b1;
               v[B_ADD] = 1'b1; v[B_CIN] = 1'b1; v[B_BUF] = 1'b1; end
      default: begin v[B_PC_ALU] = 1'b1; v[B_IR] = 1'b1; end
    endcase
    return v;
  endfunction

  function automatic logic [15:0] exec_exp(logic [1:0] op, int step);
    logic [15:0] v = '0;
    case (op)
      C_JUMP: v[B_PC_IR] = 1'b1;
      C_STORE: if (step == 1) begin v[B_MAR_IR] = 1'b1; v[B_MBR_AC] = 1'b1; end
               else v[B_WR] = 1'b1;
      default: case (step)
        1: v[B_MAR_IR] = 1'b1;
        2: begin v[B_RD] = 1'b1; v[B_MBR_MEM] = 1'b1; end
        3: if (op == C_LOAD) v[B_AC_MBR] = 1'b1;
           else begin v[B_SEL_MBR] = 1'b1; v[B_ADD] = 1'b1; v[B_BUF] = 1'b1; end
        default: v[B_AC_ALU] = 1'b1;
      endcase
    endcase
    return v;
  endfunction

  function automatic int exec_len(logic [1:0] op);
    case (op)
      C_JUMP: return 1;
      C_STORE: return 2;
      C_LOAD: return 3;
      default: return 4;
    endcase
  endfunction

  task automatic check(logic [15:0] exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: strobes actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one instruction: junk opcode during fetch, IR takes op at the fetch t3 edge
  task automatic run_instr(logic [1:0] op, logic [1:0] junk, string req);
    opcode = junk;
    check(fetch_exp(1), "R4 fetch t1");
    tick();
    check(fetch_exp(2), "R3 fetch t2");
    tick();
    check(fetch_exp(3), "R4 fetch t3");
    opcode = op;
    tick();
    for (int s = 1; s <= exec_len(op); s++) begin
      check(exec_exp(op, s), req);
      tick();
    end
    check(fetch_exp(1), "R10 back to fetch t1");
  endtask

  task automatic test_reset();
    rst_ni = 1'b0;
    #1;
    check(fetch_exp(1), "R2 during reset");
    @(negedge clk);
    rst_ni = 1'b1;
    check(fetch_exp(1), "R2 after release");
  endtask

  task automatic test_each_op();
    run_instr(C_JUMP, C_ADD, "R5 R1 jump execute");
    run_instr(C_STORE, C_LOAD, "R6 R1 store execute");
    run_instr(C_LOAD, C_JUMP, "R7 R1 load execute");
    run_instr(C_ADD, C_STORE, "R8 R1 add execute");
  endtask

  task automatic test_held_add();
    // opcode stays ADD through the following fetch
    run_instr(C_ADD, C_ADD, "R8 add then add");
    run_instr(C_ADD, C_ADD, "R4 fetch after add");
    run_instr(C_STORE, C_STORE, "R6 store held");
    run_instr(C_LOAD, C_LOAD, "R7 load held");
    run_instr(C_JUMP, C_JUMP, "R5 jump held");
  endtask

  task automatic test_mid_reset();
    run_instr(C_JUMP, C_JUMP, "R5 before reset");
    opcode = C_ADD;
    tick(); tick(); tick(); tick(); tick(); // fetch x3, add t1, add t2
    check(exec_exp(C_ADD, 3), "R8 add t3 before reset");
    rst_ni = 1'b0;
    #1;
    check(fetch_exp(1), "R10 async reset mid execute");
    @(negedge clk);
    rst_ni = 1'b1;
    run_instr(C_STORE, C_ADD, "R10 R6 store after reset");
  endtask

  task automatic test_mix();
    logic [1:0] seq [8] = '{C_LOAD, C_ADD, C_ADD, C_STORE, C_JUMP, C_ADD, C_LOAD, C_STORE};
    for (int i = 0; i < 8; i++) run_instr(seq[i], seq[(i + 3) % 8], "R9 R1 mixed program");
  endtask

  initial begin
    @(negedge clk);
    test_reset();
    test_each_op();
    test_held_add();
    test_mid_reset();
    test_mix();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule